// File: doc/BRIEF.md
# Gapped-Byte SPI Master

This block is a mode-0 SPI master that runs a transaction of one or more bytes inside a single chip-select frame. Some slow peripherals need time after a command or address byte before they can take the next one. For those, the master can hold a required minimum spacing between the ends of successive bytes. When the shift time of a byte is shorter than that spacing, the master pads the difference with idle time. During that idle time SCK stays low and chip select stays asserted.

A host pulses `start` together with a byte count, a clock divider and a spacing expressed in system clocks. The master takes every outgoing byte through a valid/ready handshake. Each incoming byte appears with a one-cycle valid strobe. The end of the frame is signalled by a one-cycle `done` pulse. The padding is computed once per transaction as the spacing minus sixteen SCK half-periods, clamped at zero.

Top module: `spi_gap_master`

## Requirements
- R1: After reset, csN is high, sck is low, and busy, txReady, done and rxValid are all low.
- R2: A start with byteCount equal to 0 produces a done pulse on the cycle after the start. In that case busy stays low and csN never goes low.
- R3: A start pulse that arrives while busy is high is ignored. The running transaction keeps its byte count and produces exactly one done.
- R4: csN falls in the cycle the first byte is accepted and stays low across every byte and every gap. The first rising edge of sck comes (clkDiv+1) system clocks after csN falls. csN rises only once all 8×byteCount rising edges have been produced.
- R5: SCK idles low. Each high phase and each low phase inside a byte lasts (clkDiv+1) system clocks. MOSI carries the byte MSB first, changes only while SCK is low, and is stable while SCK is high.
- R6: MISO is sampled on each rising edge of SCK, MSB first. rxValid is high for exactly one cycle, in the cycle of a byte's 8th rising edge, and rxData then holds that byte.
- R7: Let H = clkDiv+1 and gap = minSpacing − 16·H when that value is positive. The low time from a byte's last falling edge to the next byte's first rising edge is then gap+1+H system clocks, as long as txValid is high whenever txReady is high.
- R8: When 16·H is greater than or equal to minSpacing, no gap is inserted. The low time between bytes is then H+1 system clocks.
- R9: SCK makes no edge and is never high while csN is high.
- R10: csN rises H system clocks after the last falling edge of the final byte. done pulses for one cycle in that same cycle, and busy is low from then on.
- R11: txReady is high only between bytes, while SCK is low. Exactly byteCount handshakes complete per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transaction |
| byteCount | input | CNT_W | Bytes in the transaction, sampled at start |
| clkDiv | input | DIV_W | SCK half-period minus one, in system clocks |
| minSpacing | input | SPACE_W | Minimum end-to-end byte spacing, in system clocks |
| txData | input | 8 | Next byte to transmit |
| txValid | input | 1 | txData is valid |
| txReady | output | 1 | Master accepts txData this cycle |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle strobe: rxData is new |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle strobe at the end of a transaction |
| sck | output | 1 | Serial clock, idle low |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The properties assume that start, byteCount, clkDiv, minSpacing, txValid and miso are synchronous to clk. They also assume that miso settles between SCK edges, since the design samples it in the same cycle its SCK register rises. Stimulus drives every input at the falling edge of clk. The stimulus changes the configuration only while the master is idle, and it holds txValid high so that the padded low time between bytes is exactly predictable. The slave model in the bench updates miso only after each SCK rising edge. The ignored-start case is exercised by a second start pulse, with a different count, sent in the middle of a frame.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SHIFT,
    ST_GAP,
    ST_TAIL
  } ctrlState_t;

  typedef struct packed {
    logic loadByte;
    logic csAssert;
    logic riseSck;
    logic lastBit;
    logic fallSck;
    logic csRelease;
  } strobes_t;

endpackage

// File: rtl/spi_gap_calc.sv
module spi_gap_calc #(
  parameter int DIV_W   = 8,
  parameter int SPACE_W = 16
) (
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic [SPACE_W-1:0] minSpacing,
  output logic [SPACE_W-1:0] gapCycles
);
  import spi_gap_pkg::*;

  localparam int SHIFT_LOG = $clog2(2 * BYTE_W);
  localparam int TIME_W    = DIV_W + 1 + SHIFT_LOG;
  localparam int CMP_W     = (TIME_W > SPACE_W) ? TIME_W : SPACE_W;

  logic [DIV_W:0]     halfLen;
  logic [CMP_W-1:0]   byteTime;
  logic [CMP_W-1:0]   spacingWide;
  logic [CMP_W-1:0]   diff;

  always_comb begin
    halfLen     = {1'b0, clkDiv} + (DIV_W+1)'(1);
    byteTime    = CMP_W'(halfLen) << SHIFT_LOG;
    spacingWide = CMP_W'(minSpacing);
    diff        = (spacingWide > byteTime) ? (spacingWide - byteTime) : '0;
    gapCycles   = SPACE_W'(diff);
  end

endmodule

// File: rtl/spi_gap_ctrl.sv
module spi_gap_ctrl #(
  parameter int DIV_W   = 8,
  parameter int CNT_W   = 8,
  parameter int SPACE_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [CNT_W-1:0]          byteCount,
  input  logic [DIV_W-1:0]          clkDiv,
  input  logic [SPACE_W-1:0]        gapIn,
  input  logic                      txValid,
  output logic                      txReady,
  output logic                      busy,
  output logic                      done,
  output spi_gap_pkg::strobes_t     stb
);
  import spi_gap_pkg::*;

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  ctrlState_t         state;
  logic [DIV_W-1:0]   halfLen;
  logic [DIV_W-1:0]   halfCnt;
  logic [SPACE_W-1:0] gapLen;
  logic [SPACE_W-1:0] gapCnt;
  logic [CNT_W-1:0]   bytesLeft;
  logic [BIT_W-1:0]   bitCnt;
  logic               phaseHigh;
  logic               doneReg;

  assign txReady = (state == ST_FETCH);
  assign busy    = (state != ST_IDLE);
  assign done    = doneReg;

  always_comb begin
    stb = '0;
    if (state == ST_FETCH && txValid) begin
      stb.loadByte = 1'b1;
      stb.csAssert = 1'b1;
    end
    if (state == ST_SHIFT && halfCnt == '0) begin
      if (!phaseHigh) begin
        stb.riseSck = 1'b1;
        stb.lastBit = (bitCnt == LAST_BIT);
      end else begin
        stb.fallSck = 1'b1;
      end
    end
    if (state == ST_TAIL && halfCnt == '0) begin
      stb.csRelease = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      halfLen   <= '0;
      halfCnt   <= '0;
      gapLen    <= '0;
      gapCnt    <= '0;
      bytesLeft <= '0;
      bitCnt    <= '0;
      phaseHigh <= 1'b0;
      doneReg   <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (byteCount == '0) begin
              doneReg <= 1'b1;
            end else begin
              bytesLeft <= byteCount;
              halfLen   <= clkDiv;
              gapLen    <= gapIn;
              state     <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (txValid) begin
            halfCnt   <= halfLen;
            bitCnt    <= '0;
            phaseHigh <= 1'b0;
            state     <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (halfCnt != '0) begin
            halfCnt <= halfCnt - DIV_W'(1);
          end else begin
            halfCnt   <= halfLen;
            phaseHigh <= !phaseHigh;
            if (phaseHigh) begin
              if (bitCnt == LAST_BIT) begin
                bytesLeft <= bytesLeft - CNT_W'(1);
                if (bytesLeft == CNT_W'(1)) begin
                  state <= ST_TAIL;
                end else if (gapLen == '0) begin
                  state <= ST_FETCH;
                end else begin
                  gapCnt <= gapLen - SPACE_W'(1);
                  state  <= ST_GAP;
                end
              end else begin
                bitCnt <= bitCnt + BIT_W'(1);
              end
            end
          end
        end
        ST_GAP: begin
          if (gapCnt == '0) begin
            state <= ST_FETCH;
          end else begin
            gapCnt <= gapCnt - SPACE_W'(1);
          end
        end
        ST_TAIL: begin
          if (halfCnt == '0) begin
            doneReg <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            halfCnt <= halfCnt - DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_gap_datapath.sv
module spi_gap_datapath (
  input  logic                              clk,
  input  logic                              rstN,
  input  spi_gap_pkg::strobes_t             stb,
  input  logic [spi_gap_pkg::BYTE_W-1:0]    txData,
  input  logic                              miso,
  output logic                              sck,
  output logic                              csN,
  output logic                              mosi,
  output logic [spi_gap_pkg::BYTE_W-1:0]    rxData,
  output logic                              rxValid
);
  import spi_gap_pkg::*;

  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] rxNext;

  assign mosi   = txShift[BYTE_W-1];
  assign rxNext = {rxShift[BYTE_W-2:0], miso};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sck <= 1'b0;
      csN <= 1'b1;
    end else begin
      if (stb.riseSck)        sck <= 1'b1;
      else if (stb.fallSck)   sck <= 1'b0;
      if (stb.csAssert)       csN <= 1'b0;
      else if (stb.csRelease) csN <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (stb.loadByte) begin
      txShift <= txData;
    end else if (stb.fallSck) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= stb.riseSck && stb.lastBit;
      if (stb.riseSck) begin
        rxShift <= rxNext;
        if (stb.lastBit) rxData <= rxNext;
      end
    end
  end

endmodule

// File: rtl/spi_gap_master.sv
module spi_gap_master #(
  parameter int DIV_W   = 8,
  parameter int CNT_W   = 8,
  parameter int SPACE_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CNT_W-1:0]   byteCount,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic [SPACE_W-1:0] minSpacing,
  input  logic [7:0]         txData,
  input  logic               txValid,
  output logic               txReady,
  output logic [7:0]         rxData,
  output logic               rxValid,
  output logic               busy,
  output logic               done,
  output logic               sck,
  output logic               csN,
  output logic               mosi,
  input  logic               miso
);
  import spi_gap_pkg::*;

  strobes_t           stb;
  logic [SPACE_W-1:0] gapCycles;

  spi_gap_calc #(
    .DIV_W   (DIV_W),
    .SPACE_W (SPACE_W)
  ) u_calc (
    .clkDiv     (clkDiv),
    .minSpacing (minSpacing),
    .gapCycles  (gapCycles)
  );

  spi_gap_ctrl #(
    .DIV_W   (DIV_W),
    .CNT_W   (CNT_W),
    .SPACE_W (SPACE_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .byteCount (byteCount),
    .clkDiv    (clkDiv),
    .gapIn     (gapCycles),
    .txValid   (txValid),
    .txReady   (txReady),
    .busy      (busy),
    .done      (done),
    .stb       (stb)
  );

  spi_gap_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .txData  (txData),
    .miso    (miso),
    .sck     (sck),
    .csN     (csN),
    .mosi    (mosi),
    .rxData  (rxData),
    .rxValid (rxValid)
  );

endmodule

// File: rtl/spi_gap_checker.sv
module spi_gap_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic sck,
  input logic csN,
  input logic mosi,
  input logic txReady,
  input logic rxValid,
  input logic busy,
  input logic done
);

  AST_SCK_HIGH_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !csN);  // R9

  AST_SCK_EDGE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sck) |-> !csN);  // R9

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));  // R5

  AST_RX_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $rose(sck));  // R6

  AST_FETCH_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (!sck && busy));  // R11

  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && !busy));  // R10

  AST_CS_RISE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> done);  // R4

  AST_START_BUSY_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy && txReady) |=> busy);  // R3

endmodule

bind spi_gap_master spi_gap_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .sck     (sck),
  .csN     (csN),
  .mosi    (mosi),
  .txReady (txReady),
  .rxValid (rxValid),
  .busy    (busy),
  .done    (done)
);

// File: tb/test_spi_gap_master.sv
`timescale 1ns/1ps
module test_spi_gap_master;

  typedef struct packed {
    logic [7:0]  div;
    logic [15:0] space;
    logic [7:0]  n;
    logic [7:0]  txBase;
    logic [7:0]  rxBase;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 16'd40,  8'd3, 8'hA5, 8'h3C},
    '{8'd1, 16'd20,  8'd2, 8'h81, 8'hF0},
    '{8'd3, 16'd64,  8'd2, 8'h5A, 8'h0F},
    '{8'd3, 16'd65,  8'd2, 8'hC3, 8'h99},
    '{8'd2, 16'd100, 8'd4, 8'h10, 8'h6E},
    '{8'd1, 16'd0,   8'd1, 8'hFE, 8'h01}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  byteCount = '0;
  logic [7:0]  clkDiv = '0;
  logic [15:0] minSpacing = '0;
  logic [7:0]  txData;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [7:0]  rxData;
  logic        rxValid;
  logic        busy;
  logic        done;
  logic        sck;
  logic        csN;
  logic        mosi;
  logic        miso;

  always #10 clk = ~clk;

  spi_gap_master i_spi_gap_master (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .byteCount  (byteCount),
    .clkDiv     (clkDiv),
    .minSpacing (minSpacing),
    .txData     (txData),
    .txValid    (txValid),
    .txReady    (txReady),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .busy       (busy),
    .done       (done),
    .sck        (sck),
    .csN        (csN),
    .mosi       (mosi),
    .miso       (miso)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int curH = 1;
  int curN = 0;
  int expLow = 0;
  bit gapOn = 1'b0;
  logic [7:0] curTxBase = '0;
  logic [7:0] curRxBase = '0;

  int txIdx = 0;
  int hsCnt = 0;
  int slaveRises = 0;
  logic [7:0] slaveRx = '0;
  logic [7:0] slaveResp;

  int cyc = 0;
  int monRises = 0;
  int riseCyc = 0;
  int lastFallCyc = 0;
  int anyFallCyc = 0;
  int csFallCyc = 0;
  int rxCnt = 0;
  int doneCnt = 0;
  logic prevSck = 1'b0;
  logic prevCs = 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  assign txData    = curTxBase + 8'(txIdx);
  assign slaveResp = curRxBase ^ 8'(slaveRises / 8);
  assign miso      = slaveResp[7 - (slaveRises % 8)];

  // Handshake counter for R11
  always @(posedge clk) begin
    if (txReady && txValid) begin
      txIdx <= txIdx + 1;
      hsCnt <= hsCnt + 1;
    end
  end

  // Slave model: captures MOSI MSB first on SCK rise (R5)
  always @(posedge sck) begin
    slaveRx = {slaveRx[6:0], mosi};
    if (slaveRises % 8 == 7) begin
      check(slaveRx == curTxBase + 8'(slaveRises / 8), "R5 mosi byte", int'(slaveRx),
            int'(curTxBase + 8'(slaveRises / 8)));
    end
    slaveRises = slaveRises + 1;
  end

  // Port monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (!csN && prevCs) csFallCyc = cyc;
      if (sck && !prevSck) begin
        if (monRises % 8 == 0) begin
          if (monRises == 0)
            check(cyc - csFallCyc == curH, "R4 cs-to-first-rise", cyc - csFallCyc, curH);
          else
            check(cyc - lastFallCyc == expLow, gapOn ? "R7 gap low time" : "R8 no-gap low time",
                  cyc - lastFallCyc, expLow);
        end else begin
          check(cyc - anyFallCyc == curH, "R5 low half", cyc - anyFallCyc, curH);
        end
        monRises++;
        riseCyc = cyc;
      end
      if (!sck && prevSck) begin
        check(cyc - riseCyc == curH, "R5 high half", cyc - riseCyc, curH);
        anyFallCyc = cyc;
        if (monRises % 8 == 0) lastFallCyc = cyc;
      end
      if (sck) check(!csN, "R9 sck high with cs idle", int'(csN), 0);
      if (csN && !prevCs) begin
        check(cyc - lastFallCyc == curH, "R10 cs release delay", cyc - lastFallCyc, curH);
        check(done, "R10 done with cs rise", int'(done), 1);
        check(monRises == 8 * curN, "R4 rises inside frame", monRises, 8 * curN);
      end
      if (rxValid) begin
        check(rxData == (curRxBase ^ 8'(rxCnt)), "R6 rx byte", int'(rxData),
              int'(curRxBase ^ 8'(rxCnt)));
        rxCnt++;
      end
      if (done) doneCnt++;
    end
    prevSck = sck;
    prevCs  = csN;
  end

  task automatic runVec(input int vi, input bit poke);
    vec_t v;
    int gap;
    int guard;
    v = VECS[vi];
    curH = int'(v.div) + 1;
    curN = int'(v.n);
    gap = int'(v.space) - 16 * curH;
    if (gap < 0) gap = 0;
    gapOn = (gap > 0);
    expLow = gap + 1 + curH;
    curTxBase = v.txBase;
    curRxBase = v.rxBase;
    txIdx <= 0;
    hsCnt <= 0;
    slaveRises = 0;
    monRises = 0;
    rxCnt = 0;
    doneCnt = 0;
    clkDiv = v.div;
    minSpacing = v.space;
    byteCount = v.n;
    txValid = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      byteCount = 8'd5;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      byteCount = v.n;
    end
    guard = 0;
    while (doneCnt == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 5000, "R10 transaction completes", guard, 0);
    repeat (4) @(negedge clk);
    check(rxCnt == curN, "R6 rx count", rxCnt, curN);
    check(hsCnt == curN, "R11 handshakes", hsCnt, curN);
    check(doneCnt == 1, poke ? "R3 single done" : "R10 single done", doneCnt, 1);
    check(monRises == 8 * curN, poke ? "R3 byte count kept" : "R4 total rises", monRises, 8 * curN);
    check(!busy && csN, "R10 idle after done", int'(busy), 0);
    txValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(csN == 1'b1, "R1 csN reset", int'(csN), 1);
    check(sck == 1'b0, "R1 sck reset", int'(sck), 0);
    check({busy, txReady, done, rxValid} == 4'b0, "R1 flags reset",
          int'({busy, txReady, done, rxValid}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && csN && !sck, "R1 idle after reset", int'(busy), 0);

    for (int i = 0; i < NV; i++) begin
      runVec(i, i == 0);
    end

    // R2: zero byte count completes at once
    doneCnt = 0;
    byteCount = 8'd0;
    clkDiv = 8'd1;
    minSpacing = 16'd10;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R2 done next cycle", int'(done), 1);
    check(csN == 1'b1, "R2 cs untouched", int'(csN), 1);
    check(busy == 1'b0, "R2 never busy", int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R2 done one cycle", int'(done), 0);
    check(csN == 1'b1 && !sck, "R2 bus quiet", int'(csN), 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule